// File: doc/BRIEF.md
# Region-Based Access Permission Checker

This block sits beside a processor's load/store path and decides, for every physical access, whether that access may proceed. It performs no address translation: the address is only compared against a small set of programmable regions, and the block drives a single abort flag. The check is purely combinational, so the verdict is available in the same cycle the access is presented.

Each region is configured through one 32-bit register word written over a simple write port. The word holds the region's base, a power-of-two size code, a two-bit permission code and an enable bit. When several enabled regions contain the address, the one with the highest index wins. An address that no enabled region covers is aborted, as is an access that the winning region's permission code does not allow for the given privilege level and direction.

Top module: `region_guard`

## Requirements
- R1: A configuration write (`cfg_we_i`=1) stores `cfg_data_i` into the region selected by `cfg_idx_i` (regions 0 to 7); other regions keep their words. Word layout: bits [31:12] base, bits [11:8] unused, bits [7:6] permission code, bits [5:1] size code n, bit 0 enable.
- R2: A region with size code n covers 2^(n+1) bytes starting at the base rounded down to that size; codes below 11 act as 11 (4 KB), so address bits below the region size are ignored in the base.
- R3: Size code 31 covers the whole 4 GB address space.
- R4: A region with enable bit 0 never matches any address.
- R5: An address covered by no enabled region raises `abort_o`.
- R6: When several enabled regions cover the address, only the highest-numbered one decides the outcome.
- R7: Permission code 0 (no access) aborts every access.
- R8: Permission code 1 (privileged only) allows privileged reads and writes and aborts all user accesses.
- R9: Permission code 2 allows every privileged access and user reads, and aborts user writes.
- R10: Permission code 3 (full access) allows every access.
- R11: `abort_o` depends combinationally on the access inputs in the same cycle; a configuration write takes effect from the cycle after the clock edge that captures it and not in its own cycle.
- R12: After reset every region is disabled, so every access aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Region register write strobe |
| cfg_idx_i | input | 3 | Region index to write |
| cfg_data_i | input | 32 | Region register word |
| acc_addr_i | input | 32 | Physical address of the access |
| acc_write_i | input | 1 | 1 for a write, 0 for a read |
| acc_priv_i | input | 1 | 1 for a privileged access, 0 for user |
| abort_o | output | 1 | 1 when the access is not allowed |

## Verification
A configuration write and an access check can fall in the same cycle, and the check must then still use the old region setting. The bench provokes this by presenting a write that turns a denied address into an allowed one together with an access to that address, sampling `abort_o` before the capturing edge and again after it. The first sample must match the old configuration and the second the new one, both predicted by a bench reference model of the region table.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

  typedef enum logic [1:0] {
    PERM_NONE     = 2'd0,
    PERM_PRIV     = 2'd1,
    PERM_PRIV_URO = 2'd2,
    PERM_FULL     = 2'd3
  } perm_e;

  // region word field positions
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned SIZE_LSB = 1;
  localparam int unsigned SIZE_W   = 5;
  localparam int unsigned PERM_LSB = 6;
  localparam int unsigned PERM_W   = 2;

endpackage

// File: rtl/rg_cfg_bank.sv
module rg_cfg_bank #(
  parameter int unsigned N_REGIONS = 8,
  parameter int unsigned ADDR_W    = 32,
  localparam int unsigned IDX_W    = $clog2(N_REGIONS)
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 we_i,
  input  logic [IDX_W-1:0]                     idx_i,
  input  logic [ADDR_W-1:0]                    data_i,
  output logic [N_REGIONS-1:0][ADDR_W-1:0]     cfg_o
);

  for (genvar i = 0; i < N_REGIONS; i++) begin : g_reg
    logic sel;
    assign sel = we_i && (idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cfg_o[i] <= '0;
      else if (sel) cfg_o[i] <= data_i;
    end

    a_r11_cfg_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && idx_i == IDX_W'(i)) |=> (cfg_o[i] == $past(data_i)));

    a_r1_hold_unselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && idx_i == IDX_W'(i)) |=> $stable(cfg_o[i]));
  end

endmodule

// File: rtl/rg_region_match.sv
module rg_region_match
  import region_guard_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_SHIFT = 12,
  localparam int unsigned MIN_CODE  = PAGE_SHIFT - 1,
  localparam int unsigned MAX_CODE  = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output perm_e             perm_o
);

  logic [SIZE_W-1:0] code, eff;
  logic [SIZE_W:0]   shamt;
  logic [ADDR_W:0]   span;
  logic [ADDR_W-1:0] low, mask;

  assign code   = cfg_i[SIZE_LSB +: SIZE_W];
  assign perm_o = perm_e'(cfg_i[PERM_LSB +: PERM_W]);

  always_comb begin
    if (code < SIZE_W'(MIN_CODE))      eff = SIZE_W'(MIN_CODE);
    else if (code > SIZE_W'(MAX_CODE)) eff = SIZE_W'(MAX_CODE);
    else                               eff = code;
    shamt = {1'b0, eff} + (SIZE_W+1)'(1);
    span  = (ADDR_W+1)'(1) << shamt;
    // full-space region: span low bits are zero, wraps to all ones
    low   = span[ADDR_W-1:0] - ADDR_W'(1);
    mask  = ~low;
  end

  // field bits sit below the minimum region size, so mask drops them
  assign hit_o = cfg_i[EN_BIT] && (((addr_i ^ cfg_i) & mask) == '0);

endmodule

// File: rtl/rg_perm_check.sv
module rg_perm_check
  import region_guard_pkg::*;
(
  input  perm_e perm_i,
  input  logic  write_i,
  input  logic  priv_i,
  output logic  ok_o
);

  always_comb begin
    unique case (perm_i)
      PERM_NONE:     ok_o = 1'b0;
      PERM_PRIV:     ok_o = priv_i;
      PERM_PRIV_URO: ok_o = priv_i || !write_i;
      PERM_FULL:     ok_o = 1'b1;
      default:       ok_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/region_guard.sv
module region_guard
  import region_guard_pkg::*;
#(
  parameter int unsigned N_REGIONS  = 8,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_SHIFT = 12,
  localparam int unsigned IDX_W     = $clog2(N_REGIONS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [ADDR_W-1:0] cfg_data_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic              acc_priv_i,
  output logic              abort_o
);

  logic [N_REGIONS-1:0][ADDR_W-1:0] cfg;
  logic [N_REGIONS-1:0]             hit_vec;
  perm_e                            perm_vec [N_REGIONS];
  logic                             win_any;
  perm_e                            win_perm;
  logic                             perm_ok;

  rg_cfg_bank #(.N_REGIONS(N_REGIONS), .ADDR_W(ADDR_W)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we_i),
    .idx_i (cfg_idx_i),
    .data_i(cfg_data_i),
    .cfg_o (cfg)
  );

  for (genvar i = 0; i < N_REGIONS; i++) begin : g_match
    rg_region_match #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_match (
      .cfg_i (cfg[i]),
      .addr_i(acc_addr_i),
      .hit_o (hit_vec[i]),
      .perm_o(perm_vec[i])
    );
  end

  // ascending scan: a later hit overrides, so the highest index wins
  always_comb begin
    win_any  = 1'b0;
    win_perm = PERM_NONE;
    for (int i = 0; i < N_REGIONS; i++) begin
      if (hit_vec[i]) begin
        win_any  = 1'b1;
        win_perm = perm_vec[i];
      end
    end
  end

  rg_perm_check u_perm (
    .perm_i (win_perm),
    .write_i(acc_write_i),
    .priv_i (acc_priv_i),
    .ok_o   (perm_ok)
  );

  assign abort_o = !(win_any && perm_ok);

  a_r5_unmapped_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_vec == '0) |-> abort_o);

  a_r7_none_denies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_any && win_perm == PERM_NONE) |-> abort_o);

  a_r9_user_write_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_any && win_perm == PERM_PRIV_URO && !acc_priv_i && acc_write_i) |-> abort_o);

  a_r10_full_allows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_any && win_perm == PERM_FULL) |-> !abort_o);

endmodule

// File: tb/region_guard_tb_top.sv
module region_guard_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        acc_priv = 1'b0;
  logic        abort;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] mdl [8];

  always #5 clk = ~clk;

  region_guard dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_we_i   (cfg_we),
    .cfg_idx_i  (cfg_idx),
    .cfg_data_i (cfg_data),
    .acc_addr_i (acc_addr),
    .acc_write_i(acc_write),
    .acc_priv_i (acc_priv),
    .abort_o    (abort)
  );

  function automatic logic [31:0] mk(input logic [31:0] base, input int code,
                                     input int perm, input bit en);
    return {base[31:12], 4'b0, 2'(perm), 5'(code), en};
  endfunction

  function automatic logic exp_abort(input logic [31:0] a, input logic w, input logic p);
    logic allow = 1'b0;
    for (int i = 0; i < 8; i++) begin
      int n = int'(mdl[i][5:1]);
      longint unsigned span;
      logic [31:0] m;
      if (n < 11) n = 11;
      span = 64'd1 << (n + 1);
      m = ~32'(span - 64'd1);
      if (mdl[i][0] && (((a ^ {mdl[i][31:12], 12'b0}) & m) == 32'b0)) begin
        case (mdl[i][7:6])
          2'd0: allow = 1'b0;
          2'd1: allow = p;
          2'd2: allow = p | ~w;
          default: allow = 1'b1;
        endcase
      end
    end
    return ~allow;
  endfunction

  task automatic compare(input string tag);
    logic e = exp_abort(acc_addr, acc_write, acc_priv);
    checks++;
    if (abort !== e) begin
      bad++;
      $display("FAIL %s addr=%h wr=%0b priv=%0b abort=%0b expected=%0b",
               tag, acc_addr, acc_write, acc_priv, abort, e);
    end
  endtask

  task automatic chk(input logic [31:0] a, input logic w, input logic p, input string tag);
    @(negedge clk);
    acc_addr = a; acc_write = w; acc_priv = p;
    #1 compare(tag);
  endtask

  task automatic cfg_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_data = d;
    @(posedge clk);
    mdl[idx] = d;
    #1 cfg_we = 1'b0;
  endtask

  // write and access in the same cycle: old setting must still apply
  task automatic cfg_write_probe(input int idx, input logic [31:0] d,
                                 input logic [31:0] a, input logic w, input logic p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_data = d;
    acc_addr = a; acc_write = w; acc_priv = p;
    #1 compare("R11 same-cycle");
    @(posedge clk);
    mdl[idx] = d;
    #1 cfg_we = 1'b0;
    chk(a, w, p, "R11 next-cycle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    void'($urandom(32'h5eed_2024));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R12: reset state
    chk(32'h0000_0000, 1'b0, 1'b1, "R12");
    chk(32'hFFFF_F000, 1'b1, 1'b0, "R12");

    // R2 / R10: 4 KB full-access region
    cfg_write(0, mk(32'h0001_0000, 11, 3, 1));
    chk(32'h0001_0ABC, 1'b0, 1'b0, "R2");
    chk(32'h0001_0ABC, 1'b1, 1'b0, "R10");
    chk(32'h0001_1000, 1'b0, 1'b1, "R5");
    chk(32'h0000_FFFF, 1'b0, 1'b1, "R5");

    // R2: small size code clamps to 4 KB
    cfg_write(1, mk(32'h0002_0000, 5, 3, 1));
    chk(32'h0002_0FFF, 1'b0, 1'b0, "R2");
    chk(32'h0002_1000, 1'b0, 1'b0, "R2");

    // R8: privileged only, 64 KB
    cfg_write(2, mk(32'h0004_0000, 15, 1, 1));
    chk(32'h0004_FFFC, 1'b1, 1'b1, "R8");
    chk(32'h0004_FFFC, 1'b0, 1'b0, "R8");

    // R9 / R6: unaligned base overlaps region 2 and wins
    cfg_write(3, mk(32'h0004_8000, 15, 2, 1));
    chk(32'h0004_0010, 1'b1, 1'b1, "R9");
    chk(32'h0004_0010, 1'b0, 1'b0, "R6");
    chk(32'h0004_0010, 1'b1, 1'b0, "R9");

    // R3 / R7: whole space, no access, overrides lower regions
    cfg_write(4, mk(32'h0000_0000, 31, 0, 1));
    chk(32'h8000_0000, 1'b0, 1'b1, "R7");
    chk(32'h0001_0000, 1'b0, 1'b1, "R6");
    chk(32'hFFFF_FFFC, 1'b0, 1'b1, "R3");

    // R4: disabled region no longer matches
    cfg_write(4, mk(32'h0000_0000, 31, 0, 0));
    chk(32'h0001_0000, 1'b0, 1'b0, "R4");
    chk(32'h8000_0000, 1'b0, 1'b1, "R4");

    // R11: write and access in the same cycle
    cfg_write_probe(5, mk(32'h0000_0000, 31, 3, 1), 32'h8000_0000, 1'b1, 1'b0);
    chk(32'hFFFF_FFFC, 1'b1, 1'b0, "R3");

    // R6 / R8: top region privileged only
    cfg_write(7, mk(32'h0000_0000, 31, 1, 1));
    chk(32'h0001_0000, 1'b0, 1'b0, "R6");
    chk(32'h0001_0000, 1'b1, 1'b1, "R8");

    // R1: writing one region leaves another untouched
    cfg_write(6, mk(32'h0010_0000, 20, 2, 1));
    chk(32'h0010_0004, 1'b1, 1'b0, "R1");
    chk(32'h0004_0010, 1'b1, 1'b1, "R1");

    // R1 / R6: constrained random mix
    for (int it = 0; it < 600; it++) begin
      if (it % 12 == 0) begin
        int code = ($urandom % 4 == 0) ? 11 + int'($urandom % 21) : 11 + int'($urandom % 8);
        cfg_write(int'($urandom % 8),
                  mk({4'h0, 28'($urandom)} & 32'h00FF_F000, code,
                     int'($urandom % 4), ($urandom % 5) != 0));
      end
      begin
        int r = int'($urandom % 8);
        int sh = int'($urandom % 24);
        logic [31:0] a = {mdl[r][31:12], 12'b0} ^ ($urandom & 32'((64'd1 << sh) - 1));
        if ($urandom % 10 == 0) a = $urandom;
        chk(a, 1'($urandom), 1'($urandom), "R6 random");
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule